// File: doc/BRIEF.md
# Overload Restart and Diagnostic Sequencer

This block supervises four amplifier output channels. Each channel has its own sequencer, which watches the overload flag raised by the short-circuit protection. When an overload appears, the sequencer disables only that channel. What it does next depends on the diagnostic enable. With diagnostics off, the channel simply re-examines the overload on every millisecond tick and comes back on once the overload has gone.

With diagnostics on and the sequencer armed, the first overload leads to a confirmation check at the next tick. This check filters out short recirculation spikes. If the overload has vanished by then, the channel resumes and no diagnostic runs. If it persists, a measurement window of `CYC_LEN` ticks follows. During that window each fault class (short to ground, short to supply, shorted load) counts only if it is present on every clock. At the end of the window, one prioritised code is latched, a done flag is raised, and the channel drops back to autonomous tick-by-tick restart polling.

A status read is signalled by the re-arm strobe. The strobe clears the done flag and the latched codes, and it permits the next window. A read therefore returns the previous window's result. Once a fault has been removed, a second read is needed before the status shows the change. When several faults coexist, they are reported one per window, in priority order.

Top module: `rsd_quad`

## Requirements
- R1: An overload on a running channel clears that channel's enable on the next clock; the enables of the other channels are unaffected.
- R2: A channel shut down in restart polling stays disabled until a millisecond tick arrives while its overload is low, and it is enabled again on the clock after that tick.
- R3: With diagnostics enabled and the channel armed, if the overload has cleared by the first tick after it appeared, the channel resumes, no window runs, and the done flag and code stay at zero.
- R4: If the overload is still present at that confirmation tick, a window of exactly `CYC_LEN` further ticks runs with the channel disabled. At its end, the code is latched, done rises, and the channel returns to restart polling.
- R5: Each channel's code occupies bits [3i+2:3i] of `fault_o`: bit 0 means short to ground, bit 1 means short to supply, bit 2 means shorted load. At most one bit is set, with the priority ground, then supply, then load.
- R6: A fault class is reported only if its input was high on every clock of the window.
- R7: After a window ends, no new window starts on that channel until a re-arm strobe. After a re-arm, a channel still overloaded in restart polling starts a new window at its next tick, without a confirmation check.
- R8: The re-arm strobe clears the done flags and the latched codes, so that the second read after a fault is removed shows zero.
- R9: After reset, all channels are enabled and armed, and all codes and done flags are zero.
- R10: A latched code changes only at the end of a window or on a re-arm strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ms_tick | input | 1 | One-clock pulse every millisecond |
| diag_en_i | input | 1 | Diagnostic mode enable |
| rearm_i | input | 1 | Status-read strobe, one clock |
| ovl_i | input | NCH | Per-channel overload from short-circuit protection |
| gnd_i | input | NCH | Per-channel short-to-ground classification |
| sup_i | input | NCH | Per-channel short-to-supply classification |
| load_i | input | NCH | Per-channel shorted-load classification |
| ch_en_o | output | NCH | Per-channel output stage enable |
| fault_o | output | 3*NCH | Latched fault codes, 3 bits per channel |
| done_o | output | NCH | Per-channel window-complete flag |

## Verification
If a channel's state register is wrong, it shows first on `ch_en_o`, either one clock after an overload or one clock after the deciding tick. A miscounting window counter moves the rise of `done_o` away from the `CYC_LEN`-th tick, so the bench samples on both sides of that tick. A stability mask or arming flag that is corrupted stays hidden until the end of a window or the next strobe. At that point it appears as a wrong code, a stale code, or a window that starts without a re-arm.

// File: rtl/rsd_pkg.sv
package rsd_pkg;
  localparam int CLASS_W  = 3;
  localparam int IDX_GND  = 0;
  localparam int IDX_SUP  = 1;
  localparam int IDX_LOAD = 2;

  typedef enum logic [1:0] {
    ST_RUN     = 2'd0,
    ST_CONFIRM = 2'd1,
    ST_DIAG    = 2'd2,
    ST_RETRY   = 2'd3
  } chan_state_t;

  typedef logic [CLASS_W-1:0] fault_code_t;

  // keep only the highest-priority class that survived the window
  function automatic fault_code_t pick_fault(input fault_code_t stable_set);
    fault_code_t r;
    r = '0;
    if (stable_set[IDX_GND])       r[IDX_GND]  = 1'b1;
    else if (stable_set[IDX_SUP])  r[IDX_SUP]  = 1'b1;
    else if (stable_set[IDX_LOAD]) r[IDX_LOAD] = 1'b1;
    return r;
  endfunction
endpackage

// File: rtl/rsd_win_counter.sv
module rsd_win_counter #(
  parameter int CYC_LEN = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  input  logic tick,
  output logic last
);
  localparam int CW = $clog2(CYC_LEN + 1);
  localparam logic [CW-1:0] LAST_VAL = CW'(CYC_LEN - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (clr)           cnt_q <= '0;
    else if (en && tick)    cnt_q <= cnt_q + 1'b1;
  end

  assign last = en && tick && (cnt_q == LAST_VAL);
endmodule

// File: rtl/rsd_fault_window.sv
module rsd_fault_window
  import rsd_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        active,
  input  fault_code_t flags,
  output fault_code_t code_next
);
  fault_code_t stab_q;

  // sticky AND: a class drops out of the mask the first clock it is low
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      stab_q <= '0;
    else if (start)  stab_q <= '1;
    else if (active) stab_q <= stab_q & flags;
  end

  assign code_next = pick_fault(stab_q & flags);
endmodule

// File: rtl/rsd_channel.sv
module rsd_channel
  import rsd_pkg::*;
#(
  parameter int CYC_LEN = 100
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ms_tick,
  input  logic        diag_en,
  input  logic        rearm,
  input  logic        ovl,
  input  fault_code_t flags,
  output logic        ch_en,
  output fault_code_t code,
  output logic        done,
  output logic        busy,
  output logic        cyc_end
);
  chan_state_t state_q, state_d;
  logic        armed_q;
  logic        done_q;
  fault_code_t code_q;
  fault_code_t win_code;
  logic        win_last;
  logic        start;
  logic        may_diag;

  assign may_diag = diag_en && armed_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN:     if (ovl) state_d = may_diag ? ST_CONFIRM : ST_RETRY;
      ST_CONFIRM: if (ms_tick) state_d = ovl ? ST_DIAG : ST_RUN;
      ST_DIAG:    if (win_last) state_d = ST_RETRY;
      ST_RETRY: begin
        if (ms_tick) begin
          if (!ovl)          state_d = ST_RUN;
          else if (may_diag) state_d = ST_DIAG;
        end
      end
      default:    state_d = ST_RUN;
    endcase
  end

  assign start   = (state_d == ST_DIAG) && (state_q != ST_DIAG);
  assign busy    = (state_q == ST_DIAG);
  assign cyc_end = win_last;

  rsd_win_counter #(.CYC_LEN(CYC_LEN)) u_cnt (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (start),
    .en   (busy),
    .tick (ms_tick),
    .last (win_last)
  );

  rsd_fault_window u_win (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .active   (busy),
    .flags    (flags),
    .code_next(win_code)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_RUN;
      armed_q <= 1'b1;
      done_q  <= 1'b0;
      code_q  <= '0;
    end else begin
      state_q <= state_d;
      if (win_last) begin
        code_q  <= win_code;
        done_q  <= 1'b1;
        armed_q <= 1'b0;
      end else if (rearm) begin
        code_q  <= '0;
        done_q  <= 1'b0;
        armed_q <= 1'b1;
      end
    end
  end

  assign ch_en = (state_q == ST_RUN);
  assign code  = code_q;
  assign done  = done_q;
endmodule

// File: rtl/rsd_quad.sv
module rsd_quad
  import rsd_pkg::*;
#(
  parameter int NCH     = 4,
  parameter int CYC_LEN = 100
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ms_tick,
  input  logic                 diag_en_i,
  input  logic                 rearm_i,
  input  logic [NCH-1:0]       ovl_i,
  input  logic [NCH-1:0]       gnd_i,
  input  logic [NCH-1:0]       sup_i,
  input  logic [NCH-1:0]       load_i,
  output logic [NCH-1:0]       ch_en_o,
  output logic [CLASS_W*NCH-1:0] fault_o,
  output logic [NCH-1:0]       done_o
);
  logic [NCH-1:0] diag_busy;
  logic [NCH-1:0] cyc_end;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    fault_code_t flags;
    fault_code_t code;

    always_comb begin
      flags           = '0;
      flags[IDX_GND]  = gnd_i[i];
      flags[IDX_SUP]  = sup_i[i];
      flags[IDX_LOAD] = load_i[i];
    end

    rsd_channel #(.CYC_LEN(CYC_LEN)) u_ch (
      .clk    (clk),
      .rst_n  (rst_n),
      .ms_tick(ms_tick),
      .diag_en(diag_en_i),
      .rearm  (rearm_i),
      .ovl    (ovl_i[i]),
      .flags  (flags),
      .ch_en  (ch_en_o[i]),
      .code   (code),
      .done   (done_o[i]),
      .busy   (diag_busy[i]),
      .cyc_end(cyc_end[i])
    );

    assign fault_o[CLASS_W*i +: CLASS_W] = code;
  end
endmodule

// File: rtl/rsd_quad_checker.sv
module rsd_quad_checker #(
  parameter int NCH = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rearm_i,
  input logic [NCH-1:0]   ovl_i,
  input logic [NCH-1:0]   ch_en_o,
  input logic [3*NCH-1:0] fault_o,
  input logic [NCH-1:0]   done_o,
  input logic [NCH-1:0]   diag_busy,
  input logic [NCH-1:0]   cyc_end
);
  for (genvar i = 0; i < NCH; i++) begin : g_chk
    AST_EN_DROPS_ON_OVL: assert property (@(posedge clk) disable iff (!rst_n)
      ch_en_o[i] && ovl_i[i] |=> !ch_en_o[i]); // R1
    AST_END_SETS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      cyc_end[i] |=> done_o[i] && !ch_en_o[i]); // R4
    AST_CODE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(fault_o[3*i +: 3])); // R5
    AST_NO_UNARMED_START: assert property (@(posedge clk) disable iff (!rst_n)
      done_o[i] && !rearm_i |=> !$rose(diag_busy[i])); // R7
    AST_REARM_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      rearm_i && !cyc_end[i] |=> !done_o[i] && (fault_o[3*i +: 3] == 3'b000)); // R8
    AST_CODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !cyc_end[i] && !rearm_i |=> $stable(fault_o[3*i +: 3])); // R10
  end
endmodule

bind rsd_quad rsd_quad_checker #(.NCH(NCH)) u_rsd_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .rearm_i  (rearm_i),
  .ovl_i    (ovl_i),
  .ch_en_o  (ch_en_o),
  .fault_o  (fault_o),
  .done_o   (done_o),
  .diag_busy(diag_busy),
  .cyc_end  (cyc_end)
);

// File: tb/test_rsd_quad.sv
module test_rsd_quad;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 4;
  localparam int WIN = 100;
  localparam int WATCHDOG = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ms_tick = 1'b0;
  logic diag_en = 1'b0;
  logic rearm = 1'b0;
  logic [NCH-1:0] ovl = '0, gnd = '0, sup = '0, load = '0;
  logic [NCH-1:0] ch_en;
  logic [3*NCH-1:0] fault;
  logic [NCH-1:0] done;

  int vectors = 0;
  int fails = 0;
  int cycles = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rsd_quad #(.NCH(NCH), .CYC_LEN(WIN)) i_rsd_quad (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .diag_en_i(diag_en),
    .rearm_i(rearm), .ovl_i(ovl), .gnd_i(gnd), .sup_i(sup), .load_i(load),
    .ch_en_o(ch_en), .fault_o(fault), .done_o(done)
  );

  function automatic logic [2:0] exp_code(input logic g, input logic s, input logic l);
    case (1'b1)
      g:       return 3'b001;
      s:       return 3'b010;
      l:       return 3'b100;
      default: return 3'b000;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk) ms_tick = 1'b1;
      @(negedge clk) ms_tick = 1'b0;
    end
  endtask

  task automatic do_read();
    @(negedge clk) rearm = 1'b1;
    @(negedge clk) rearm = 1'b0;
  endtask

  function automatic logic [2:0] code_of(input int ch);
    return fault[3*ch +: 3];
  endfunction

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > WATCHDOG) begin
        fails++;
        $display("FAIL watchdog actual=%0d expected<%0d", cycles, WATCHDOG);
        finish_run();
      end
    end
  end

  initial begin
    int unsigned seed_set;
    seed_set = $urandom(32'd1977);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    check("R9 enables", 32'(ch_en), 32'hF);
    check("R9 codes", 32'(fault), 32'h0);
    check("R9 done", 32'(done), 32'h0);

    // R1 / R2 restart polling with diagnostics off
    diag_en = 1'b0;
    @(negedge clk) ovl[1] = 1'b1;
    @(negedge clk);
    check("R1 only ch1 off", 32'(ch_en), 32'hD);
    ticks(1);
    check("R2 stays off while overloaded", 32'(ch_en), 32'hD);
    ovl[1] = 1'b0;
    repeat (3) @(negedge clk);
    check("R2 waits for tick", 32'(ch_en), 32'hD);
    ticks(1);
    check("R2 restart after tick", 32'(ch_en), 32'hF);
    check("R2 no window", 32'(done), 32'h0);

    // R3 spike filtered by the confirmation tick
    diag_en = 1'b1;
    @(negedge clk) ovl[2] = 1'b1;
    @(negedge clk);
    check("R1 ch2 off", 32'(ch_en), 32'hB);
    ovl[2] = 1'b0;
    ticks(1);
    check("R3 resumed", 32'(ch_en), 32'hF);
    check("R3 no done", 32'(done), 32'h0);
    check("R3 no code", 32'(fault), 32'h0);

    // R4 / R5 / R7 / R8 window on ch0 with two faults
    @(negedge clk) begin ovl[0] = 1'b1; gnd[0] = 1'b1; sup[0] = 1'b1; end
    @(negedge clk);
    ticks(1);
    check("R4 off in window", 32'(ch_en[0]), 32'h0);
    ticks(WIN - 1);
    check("R4 not done one tick early", 32'(done[0]), 32'h0);
    ticks(1);
    check("R4 done at window end", 32'(done[0]), 32'h1);
    check("R5 ground wins", 32'(code_of(0)), 32'(exp_code(1'b1, 1'b1, 1'b0)));
    check("R4 back to polling, off", 32'(ch_en[0]), 32'h0);
    gnd[0] = 1'b0;
    ticks(3);
    check("R7 no new window unarmed", 32'(done[0]), 32'h1);
    check("R10 code held", 32'(code_of(0)), 32'h1);
    do_read();
    check("R8 done cleared", 32'(done), 32'h0);
    check("R8 code cleared", 32'(fault), 32'h0);
    ticks(1);
    ticks(WIN - 1);
    check("R7 rearmed window still running", 32'(done[0]), 32'h0);
    ticks(1);
    check("R7 rearmed window done", 32'(done[0]), 32'h1);
    check("R5 next fault reported", 32'(code_of(0)), 32'h2);
    @(negedge clk) begin ovl[0] = 1'b0; sup[0] = 1'b0; end
    do_read();
    check("R8 second read clear", 32'(code_of(0)), 32'h0);
    ticks(1);
    check("R2 ch0 restarted", 32'(ch_en), 32'hF);

    // R6 a class that drops for one clock is not reported
    @(negedge clk) begin ovl[3] = 1'b1; gnd[3] = 1'b1; load[3] = 1'b1; end
    @(negedge clk);
    ticks(1);
    ticks(WIN / 2);
    @(negedge clk) gnd[3] = 1'b0;
    @(negedge clk) gnd[3] = 1'b1;
    ticks(WIN - WIN / 2);
    check("R6 unstable ground dropped", 32'(code_of(3)), 32'h4);
    @(negedge clk) begin ovl[3] = 1'b0; gnd[3] = 1'b0; load[3] = 1'b0; end
    do_read();
    ticks(1);
    check("R2 all running", 32'(ch_en), 32'hF);

    // random fault mixes and spikes
    for (int it = 0; it < 20; it++) begin
      int ch;
      logic [2:0] f;
      ch = int'($urandom % NCH);
      f  = 3'($urandom % 8);
      @(negedge clk) begin ovl[ch] = 1'b1; gnd[ch] = f[0]; sup[ch] = f[1]; load[ch] = f[2]; end
      @(negedge clk);
      check("R1 random isolation", 32'(ch_en), 32'(4'hF & ~(4'b1 << ch)));
      ticks(1 + WIN);
      check("R4 random done", 32'(done[ch]), 32'h1);
      check("R5 random code", 32'(code_of(ch)), 32'(exp_code(f[0], f[1], f[2])));
      @(negedge clk) begin ovl[ch] = 1'b0; gnd[ch] = 1'b0; sup[ch] = 1'b0; load[ch] = 1'b0; end
      do_read();
      ticks(1);
      check("R2 random restart", 32'(ch_en), 32'hF);
      ch = int'($urandom % NCH);
      @(negedge clk) ovl[ch] = 1'b1;
      repeat (1 + int'($urandom % 3)) @(negedge clk);
      ovl[ch] = 1'b0;
      ticks(1);
      check("R3 random spike", 32'(ch_en), 32'hF);
      check("R3 random spike done", 32'(done), 32'h0);
    end

    finish_run();
  end
endmodule